// File: doc/BRIEF.md
# Serial Interface Counter and Flag Unit

This block sits beside the shift register of a general-purpose serial port and does that port's bookkeeping on the CPU side. It holds a small clock counter that a selectable source can step: a software strobe, a timer compare match, or an external clock edge. It also holds three sticky event flags for start condition, counter overflow and stop condition, and a live collision indication. From these it raises interrupt requests and drives two hold signals. The line logic uses those hold signals to stretch the serial clock while a start or overflow event waits for service.

Software reaches the block through a single write port with two targets. The control target stores the interrupt enables, the wire mode and the clock select, and takes two strobe bits that are never stored. The status target loads the counter and clears flags by writing ones to them. A read strobe for the data buffer register also clears the overflow flag. Both registers are visible on output ports at all times. Event inputs are single-cycle pulses from detectors outside the block.

Top module: `ser_cnt_flags`

## Requirements
- R1: While reset is applied, and on the first edge after it, every stored bit is 0, and `ctrl_q`, the flag bits of `status_q`, both interrupt requests and both holds read 0.
- R2: A control write (`reg_sel`=0) stores data bits 7..2 as: 7 start interrupt enable, 6 overflow interrupt enable, 5..4 wire mode, 3..2 clock select. `ctrl_q` bits 1..0 always read 0.
- R3: A status write (`reg_sel`=1) loads data bits 3..0 into the counter on that edge. If a counter step occurs in the same cycle, the load wins and no step or overflow happens.
- R4: The counter steps by one on an edge where: clock select is 00 and a control write has data bit 1 set; clock select is 01 and `timer_match` is high; or clock select bit 1 is set and `ext_edge` is high. The last holds whatever the wire mode. The stored select governs the pulses, and the written select governs the strobes.
- R5: A control write whose data has bits 3, 1 and 0 all set also steps the counter once, even when an external edge arrives in the same cycle.
- R6: A step from 15 wraps the count to 0 and sets the overflow flag (status bit 6). The flag clears on a status write with bit 6 set or on `buf_rd`. A wrap in the same cycle wins over a clear.
- R7: `start_det` sets the start flag (status bit 7). Only a status write with bit 7 set clears it, and `buf_rd` leaves it unchanged. A set in the same cycle wins over a clear.
- R8: `stop_det` sets the stop flag (status bit 5) only while wire mode bit 1 is 1. A status write with bit 5 set clears it.
- R9: Status bit 4 equals `shift_msb` XOR `sda_in` in the same cycle, and status writes have no effect on it.
- R10: `irq_start` equals start flag AND start enable AND `gie`. `irq_ovf` equals overflow flag AND overflow enable AND `gie`. A flag that is already pending raises its request as soon as the enables are set.
- R11: `hold_start` and `hold_ovf` follow the start and overflow flags while wire mode bit 1 is 1, and read 0 otherwise. Each releases on the edge that clears its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| buf_rd | input | 1 | Data buffer read strobe |
| start_det | input | 1 | Start condition pulse |
| stop_det | input | 1 | Stop condition pulse |
| ext_edge | input | 1 | External clock edge pulse |
| timer_match | input | 1 | Timer compare match pulse |
| shift_msb | input | 1 | Shift register most significant bit |
| sda_in | input | 1 | Sampled data pin |
| gie | input | 1 | Global interrupt enable |
| ctrl_q | output | 8 | Control register view |
| status_q | output | 8 | Status view: flags, collision, count |
| irq_start | output | 1 | Start condition interrupt request |
| irq_ovf | output | 1 | Counter overflow interrupt request |
| hold_start | output | 1 | Clock-line hold for start condition |
| hold_ovf | output | 1 | Clock-line hold for overflow |

## Verification
Every stored result (count, the three flags, the control fields and the holds derived from them) is due on the first rising edge after its stimulus. The collision bit and the interrupt requests are combinational from stored state, `gie` and the data inputs, so they follow within that same cycle. The bench drives inputs on the falling edge. On each rising edge it advances a behavioural model with the inputs present, then compares all outputs a short delay after that edge, once they have settled. Directed sequences cover wrap, load-versus-step, set-versus-clear, mode gating and pending-enable cases. A seeded random phase follows them.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  localparam int REG_W  = 8;
  localparam int CNT_W  = 4;
  localparam int N_FLAG = 3;
  // control write bit positions
  localparam int C_SIE  = 7;
  localparam int C_OIE  = 6;
  localparam int C_WM1  = 5;
  localparam int C_CS1  = 3;
  localparam int C_CS0  = 2;
  localparam int C_CSTB = 1;
  localparam int C_TSTB = 0;
  // status bit positions
  localparam int S_START = 7;
  localparam int S_OVF   = 6;
  localparam int S_STOP  = 5;
  localparam int S_COLL  = 4;
  // flag index inside the flag vector
  localparam int F_STOP  = 0;
  localparam int F_OVF   = 1;
  localparam int F_START = 2;

  typedef struct packed {
    logic       sie;
    logic       oie;
    logic [1:0] wm;
    logic [1:0] cs;
  } ctrl_t;
endpackage

// File: rtl/ser_step_sel.sv
`timescale 1ns/1ps
module ser_step_sel
  import ser_pkg::*;
(
  input  logic             ctrl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       cs_q,
  input  logic             ext_edge,
  input  logic             timer_match,
  output logic             step
);
  logic sw_step, tog_step, ext_step, tmr_step;

  always_comb begin
    sw_step  = ctrl_wr && wdata[C_CSTB] && !wdata[C_CS1] && !wdata[C_CS0];
    tog_step = ctrl_wr && wdata[C_TSTB] && wdata[C_CSTB] && wdata[C_CS1];
    ext_step = ext_edge && cs_q[1];
    tmr_step = timer_match && (cs_q == 2'b01);
    step     = sw_step || tog_step || ext_step || tmr_step;
  end
endmodule

// File: rtl/ser_counter.sv
`timescale 1ns/1ps
module ser_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || step;
    wrap   = step && !load && (cnt == MAXV);
    cnt_d  = load ? load_val : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/ser_flag.sv
`timescale 1ns/1ps
module ser_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = set_i || (q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  a_r6_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q);
endmodule

// File: rtl/ser_cnt_flags.sv
`timescale 1ns/1ps
module ser_cnt_flags
  import ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             buf_rd,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             ext_edge,
  input  logic             timer_match,
  input  logic             shift_msb,
  input  logic             sda_in,
  input  logic             gie,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] status_q,
  output logic             irq_start,
  output logic             irq_ovf,
  output logic             hold_start,
  output logic             hold_ovf
);
  ctrl_t             ctrl_r, ctrl_d;
  logic              ctrl_wr, stat_wr, two_wire;
  logic              step, wrap;
  logic [CNT_W-1:0]  cnt;
  logic [N_FLAG-1:0] f_set, f_clr, f_q;

  always_comb begin
    ctrl_wr  = reg_wr && !reg_sel;
    stat_wr  = reg_wr && reg_sel;
    two_wire = ctrl_r.wm[1];
    ctrl_d   = ctrl_wr ? ctrl_t'(reg_wdata[REG_W-1:2]) : ctrl_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_r <= '0;
    else        ctrl_r <= ctrl_d;
  end

  ser_step_sel u_step (
    .ctrl_wr     (ctrl_wr),
    .wdata       (reg_wdata),
    .cs_q        (ctrl_r.cs),
    .ext_edge    (ext_edge),
    .timer_match (timer_match),
    .step        (step)
  );

  ser_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (stat_wr),
    .load_val (reg_wdata[CNT_W-1:0]),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  always_comb begin
    f_set[F_STOP]  = stop_det && two_wire;
    f_clr[F_STOP]  = stat_wr && reg_wdata[S_STOP];
    f_set[F_OVF]   = wrap;
    f_clr[F_OVF]   = (stat_wr && reg_wdata[S_OVF]) || buf_rd;
    f_set[F_START] = start_det;
    f_clr[F_START] = stat_wr && reg_wdata[S_START];
  end

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    ser_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (f_set[i]),
      .clr_i (f_clr[i]),
      .q     (f_q[i])
    );
  end

  always_comb begin
    ctrl_q     = {ctrl_r, 2'b00};
    status_q   = {f_q[F_START], f_q[F_OVF], f_q[F_STOP], shift_msb ^ sda_in, cnt};
    irq_start  = f_q[F_START] && ctrl_r.sie && gie;
    irq_ovf    = f_q[F_OVF] && ctrl_r.oie && gie;
    hold_start = f_q[F_START] && two_wire;
    hold_ovf   = f_q[F_OVF] && two_wire;
  end

  a_r8_stop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_q[F_STOP] && !(stop_det && two_wire)) |=> !f_q[F_STOP]);
  a_r10_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_start || irq_ovf) |-> gie);
  a_r11_hold_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ovf |-> (status_q[S_OVF] && ctrl_q[C_WM1]));
  a_r7_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[S_START] && !(stat_wr && reg_wdata[S_START])) |=> status_q[S_START]);
endmodule

// File: tb/ser_cnt_flags_tb.sv
`timescale 1ns/1ps
module ser_cnt_flags_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_sel = 0, buf_rd = 0, start_det = 0, stop_det = 0;
  logic ext_edge = 0, timer_match = 0, shift_msb = 0, sda_in = 0, gie = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] ctrl_q, status_q;
  logic irq_start, irq_ovf, hold_start, hold_ovf;

  int checks = 0, failures = 0;
  bit running = 0, done = 0;
  int m_cnt = 0, m_ctrl = 0;
  bit m_sf = 0, m_of = 0, m_pf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_cnt_flags u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .buf_rd(buf_rd), .start_det(start_det),
    .stop_det(stop_det), .ext_edge(ext_edge), .timer_match(timer_match),
    .shift_msb(shift_msb), .sda_in(sda_in), .gie(gie), .ctrl_q(ctrl_q),
    .status_q(status_q), .irq_start(irq_start), .irq_ovf(irq_ovf),
    .hold_start(hold_start), .hold_ovf(hold_ovf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advanced on every edge with the inputs present
  always @(posedge clk) begin
    if (running) begin
      bit cw, sw, tw2, stp, wrp;
      int d;
      d   = reg_wdata;
      cw  = reg_wr && !reg_sel;
      sw  = reg_wr && reg_sel;
      tw2 = (m_ctrl >> 5) & 1;
      stp = 0;
      if (cw && d[1] && d[3:2] == 2'b00) stp = 1;                    // R4 software strobe
      if (cw && d[0] && d[1] && d[3]) stp = 1;                       // R5 toggle strobe
      if (ext_edge && ((m_ctrl >> 3) & 1)) stp = 1;                 // R4 external
      if (timer_match && ((m_ctrl >> 2) & 3) == 1) stp = 1;         // R4 timer
      wrp = 0;
      if (sw) m_cnt = d & 15;
      else if (stp) begin wrp = (m_cnt == 15); m_cnt = (m_cnt + 1) % 16; end
      m_sf = start_det || (m_sf && !(sw && d[7]));
      m_of = wrp || (m_of && !(sw && d[6]) && !buf_rd);
      m_pf = (stop_det && tw2) || (m_pf && !(sw && d[5]));
      if (cw) m_ctrl = d & 8'hFC;
      #1;
      chk("R2 ctrl", ctrl_q, m_ctrl);
      chk("R3/R4/R5 count", status_q[3:0], m_cnt);
      chk("R6 ovf flag", status_q[6], m_of);
      chk("R7 start flag", status_q[7], m_sf);
      chk("R8 stop flag", status_q[5], m_pf);
      chk("R9 collision", status_q[4], shift_msb ^ sda_in);
      chk("R10 irq_start", irq_start, m_sf && m_ctrl[7] && gie);
      chk("R10 irq_ovf", irq_ovf, m_of && m_ctrl[6] && gie);
      chk("R11 hold_start", hold_start, m_sf && m_ctrl[5]);
      chk("R11 hold_ovf", hold_ovf, m_of && m_ctrl[5]);
    end
  end

  task automatic drive(input bit wr, input bit sel, input int d, input bit rd,
                       input bit st, input bit sp, input bit ex, input bit tm);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = d[7:0]; buf_rd = rd;
    start_det = st; stop_det = sp; ext_edge = ex; timer_match = tm;
  endtask
  task automatic idle(); drive(0,0,0,0,0,0,0,0); endtask
  task automatic wctl(input int d); drive(1,0,d,0,0,0,0,0); endtask
  task automatic wst(input int d); drive(1,1,d,0,0,0,0,0); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state, held and after release
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ctrl in reset", ctrl_q, 0);
    chk("R1 flags in reset", status_q[7:5], 0);
    chk("R1 count in reset", status_q[3:0], 0);
    chk("R1 irq/hold in reset", {irq_start, irq_ovf, hold_start, hold_ovf}, 0);
    @(negedge clk); rst_n = 1'b1;
    running = 1;
    idle();
    // R4 software strobe, clock select 00
    repeat (3) wctl(8'h02);
    idle();
    // R6 wrap from 15 by software steps, buffer read clears
    wst(8'h0E); wctl(8'h02); wctl(8'h02); idle();
    drive(0,0,0,1,0,0,0,0); idle();
    // R4 timer source; R6 write-one clear; R6 wrap wins over clear
    wctl(8'h04); wst(8'h0F); drive(0,0,0,0,0,0,0,1); idle();
    wst(8'h40);
    wst(8'h0F); drive(0,0,0,1,0,0,0,1); idle();
    // R4 external edge with wire mode 00, and timer ignored there
    wctl(8'h08); drive(0,0,0,0,0,0,1,0); drive(0,0,0,0,0,0,1,1); idle();
    // R5 toggle strobe, together with an external edge
    wctl(8'h0B); drive(1,0,8'h0B,0,0,0,1,0); wctl(8'h09); idle();
    // R3 load wins over an external step at 15
    wst(8'h0F); drive(1,1,8'h05,0,0,0,1,0); idle();
    // R7 start flag: buffer read no effect, set wins, enables after pending (R10)
    drive(0,0,0,0,1,0,0,0); drive(0,0,0,1,0,0,0,0);
    gie = 1; wctl(8'hC8); idle();
    drive(1,1,8'h80,0,1,0,0,0); idle();
    wst(8'h80); idle();
    // R8 stop gated by wire mode; R11 holds
    drive(0,0,0,0,0,1,0,0);
    wctl(8'hE8); drive(0,0,0,0,0,1,0,0); drive(0,0,0,0,1,0,0,0);
    wst(8'h0F); drive(0,0,0,0,0,0,1,0); idle();
    wst(8'hE0); idle();
    // R9 collision patterns, write to bit 4 ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); shift_msb = i[0]; sda_in = i[1];
      wst(8'h10 | i);
    end
    gie = 0; idle();
    // random phase
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom;
      @(negedge clk);
      reg_wr = (r[2:0] == 0); reg_sel = r[3]; reg_wdata = r[15:8];
      buf_rd = (r[19:16] == 0); start_det = (r[23:20] == 0);
      stop_det = (r[27:24] == 0); ext_edge = r[28]; timer_match = r[29];
      shift_msb = r[30]; sda_in = r[31]; gie = r[4];
    end
    idle(); idle();
    running = 0; done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule